// File: doc/BRIEF.md
# External Interrupt Sense and Pending Latch

This block turns a group of active-low external interrupt pins and a group of on-chip interrupt requests into one vector of masked pending requests. The vector feeds a downstream priority encoder. Each external pin goes through a synchroniser. A per-pin control bit then chooses one of two ways to read the pin. In level mode the request follows the pin while it is held low. In edge mode a high-to-low transition is captured in a latch, and the latch holds until software acknowledges it. On-chip sources are always read as active-low levels.

Software reaches three registers through a 32-bit word port:
- the sense-control register;
- a per-source enable mask;
- a write-one-to-clear acknowledge word.

Register bits are numbered from the most significant end. Source `b` owns bit `31-b` of the mask and of the acknowledge word. The edge-select bit for pin `n` is bit `15-n` of the sense-control register. Sources `0..NUM_EXT-1` are the external pins. Sources `NUM_EXT..NUM_EXT+NUM_INT-1` are the on-chip requests.

Top module: `extirq_sense_latch`

## Requirements
- R1: After reset, `irqPend` is all zeros, and both the sense-control register (address 0) and the mask register (address 1) read back as zero, so every source is disabled and in level mode.
- R2: When pin `n` has its edge-select bit (bit `15-n` of address 0) clear, `irqPend[n]` goes high on the third rising clock edge after the pin is driven low, provided that mask bit `31-n` is set. It goes low on the third edge after the pin returns high.
- R3: When pin `n` has its edge-select bit set, a high-to-low transition raises `irqPend[n]` on the fourth rising edge after the transition, provided that the source is enabled. The request stays high after the pin returns high.
- R4: In edge mode a low-to-high transition, or a pin held at a steady level, never sets a request.
- R5: Writing to address 2 a word with bit `31-n` set clears the captured request of an edge-mode pin `n`, and `irqPend[n]` drops one edge after the write edge. Zero bits in the written word leave the other requests unchanged.
- R6: Acknowledge writes have no effect on a pin in level mode. Its request stays high while the pin is low.
- R7: When an acknowledge write for pin `n` lands in the same cycle as a new falling edge on that pin, the captured request stays set.
- R8: Mask bit `31-b` set to 1 lets source `b` reach `irqPend[b]`, and 0 blocks it. A captured edge request survives while it is masked and appears again one edge after the source is unmasked.
- R9: On-chip sources (`intReqN`) are always active-low level. `irqPend[NUM_EXT+i]` follows `!intReqN[i]` one edge later whatever the sense-control register holds.
- R10: Only bits `15..16-NUM_EXT` of address 0 and bits `31..32-NUM_SRC` of address 1 can be written and read back. All other bits read zero. Addresses 2 and 3 read zero, and a write to address 3 has no effect.
- R11: `irqPend` is registered: each bit equals the source's pending state ANDed with its mask bit as they stood before the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPinN | input | NUM_EXT | Asynchronous active-low external interrupt pins |
| intReqN | input | NUM_INT | Synchronous active-low on-chip interrupt requests |
| regAddr | input | 2 | Word address: 0 sense control, 1 mask, 2 acknowledge, 3 reserved |
| regWrEn | input | 1 | Write strobe, sampled on the rising edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| irqPend | output | NUM_EXT+NUM_INT | Registered masked pending requests, index = source number |

## Verification
The bench uses the default parameters: eight external pins, eight on-chip sources and a two-stage synchroniser. With these values the mask field fills bits 31 to 16 and the sense field fills bits 15 to 8, so every edge of both fields can be reached and checked, including the unused low byte. The two-stage synchroniser fixes the latency at three edges for a level request and four for an edge capture, which lets the directed cases place an acknowledge write exactly on the cycle a new falling edge is detected. The random phase toggles pins and issues random writes to all four addresses while a cycle model built from the requirements predicts `irqPend`.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  localparam int REG_W     = 32;
  localparam int SENSE_TOP = 15;

  typedef enum logic [1:0] {
    SEL_SENSE = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_ACK   = 2'd2,
    SEL_RSVD  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             senseWr;
    logic             maskWr;
    logic             ackWr;
    logic [REG_W-1:0] wrData;
    regSel_e          rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '1;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '1;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output ctrlStrobe_t      strobe
);

  regSel_e sel;
  assign sel = regSel_e'(regAddr);

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = sel;
    strobe.wrData  = regWrData;
    strobe.senseWr = regWrEn && (sel == SEL_SENSE);
    strobe.maskWr  = regWrEn && (sel == SEL_MASK);
    strobe.ackWr   = regWrEn && (sel == SEL_ACK);
  end

  // R10: one register at most is written per cycle; reserved address writes none
  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.senseWr, strobe.maskWr, strobe.ackWr}));

  p_rsvd_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd3) |-> !(strobe.senseWr || strobe.maskWr || strobe.ackWr));

endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int NUM_EXT     = 8,
  parameter int NUM_INT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EXT-1:0]         extPinN,
  input  logic [NUM_INT-1:0]         intReqN,
  input  ctrlStrobe_t                strobe,
  output logic [REG_W-1:0]           regRdData,
  output logic [NUM_EXT+NUM_INT-1:0] irqPend
);

  localparam int NUM_SRC = NUM_EXT + NUM_INT;
  localparam int MSB     = REG_W - 1;

  logic [NUM_EXT-1:0] syncN, prevN, fallDet, senseEdge, edgeLatch, ackVec;
  logic [NUM_SRC-1:0] maskEn, pendVec;
  logic               unusedWrBits;

  assign unusedWrBits = ^strobe.wrData;

  extirq_sync #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (extPinN),
    .syncOut (syncN)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevN <= '1;
    else       prevN <= syncN;
  end

  assign fallDet = prevN & ~syncN;

  for (genvar n = 0; n < NUM_EXT; n++) begin : g_pin
    assign ackVec[n] = strobe.ackWr & strobe.wrData[MSB-n];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                senseEdge[n] <= 1'b0;
      else if (strobe.senseWr)  senseEdge[n] <= strobe.wrData[SENSE_TOP-n];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              edgeLatch[n] <= 1'b0;
      else if (!senseEdge[n]) edgeLatch[n] <= 1'b0;
      else                    edgeLatch[n] <= (edgeLatch[n] & ~ackVec[n]) | fallDet[n];
    end

    assign pendVec[n] = senseEdge[n] ? edgeLatch[n] : ~syncN[n];

    // R3 and R7: a detected falling edge in edge mode is always captured
    p_fall_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
      (senseEdge[n] && fallDet[n]) |=> edgeLatch[n]);

    // R5: acknowledge without a new edge clears the capture
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
      (ackVec[n] && !fallDet[n]) |=> !edgeLatch[n]);

    // R4: nothing but a falling edge can set an empty capture
    p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!edgeLatch[n] && !fallDet[n]) |=> !edgeLatch[n]);

    // R2: an enabled level-mode pin held low reaches the output next edge
    p_level_out_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!senseEdge[n] && !syncN[n] && maskEn[n]) |=> irqPend[n]);
  end

  for (genvar i = 0; i < NUM_INT; i++) begin : g_int
    assign pendVec[NUM_EXT+i] = ~intReqN[i];

    // R9: on-chip sources are level requests whatever the sense register holds
    p_int_level_r9: assert property (@(posedge clk) disable iff (!rstN)
      (intReqN[i] == 1'b1) |=> !irqPend[NUM_EXT+i]);
  end

  for (genvar b = 0; b < NUM_SRC; b++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             maskEn[b] <= 1'b0;
      else if (strobe.maskWr) maskEn[b] <= strobe.wrData[MSB-b];
    end

    // R8: a blocked source never reaches the output
    p_mask_block_r8: assert property (@(posedge clk) disable iff (!rstN)
      !maskEn[b] |=> !irqPend[b]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqPend <= '0;
    else       irqPend <= pendVec & maskEn;
  end

  always_comb begin
    regRdData = '0;
    case (strobe.rdSel)
      SEL_SENSE: for (int n = 0; n < NUM_EXT; n++) regRdData[SENSE_TOP-n] = senseEdge[n];
      SEL_MASK:  for (int b = 0; b < NUM_SRC; b++) regRdData[MSB-b] = maskEn[b];
      default:   regRdData = '0;
    endcase
  end

  // R10: bits outside the sense field never read back
  p_sense_field_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == SEL_SENSE) |-> (regRdData[MSB:SENSE_TOP+1] == '0));

endmodule

// File: rtl/extirq_sense_latch.sv
module extirq_sense_latch
  import extirq_pkg::*;
#(
  parameter int NUM_EXT     = 8,
  parameter int NUM_INT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_EXT-1:0]         extPinN,
  input  logic [NUM_INT-1:0]         intReqN,
  input  logic [1:0]                 regAddr,
  input  logic                       regWrEn,
  input  logic [31:0]                regWrData,
  output logic [31:0]                regRdData,
  output logic [NUM_EXT+NUM_INT-1:0] irqPend
);

  ctrlStrobe_t strobe;

  extirq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  extirq_datapath #(
    .NUM_EXT     (NUM_EXT),
    .NUM_INT     (NUM_INT),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .extPinN   (extPinN),
    .intReqN   (intReqN),
    .strobe    (strobe),
    .regRdData (regRdData),
    .irqPend   (irqPend)
  );

endmodule

// File: tb/extirq_sense_latch_test.sv
`timescale 1ns/1ps
module extirq_sense_latch_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  extPinN = '1;
  logic [7:0]  intReqN = '1;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] irqPend;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  extirq_sense_latch uut (
    .clk(clk), .rstN(rstN), .extPinN(extPinN), .intReqN(intReqN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqPend(irqPend)
  );

  // Cycle model built from the requirements (two-stage synchroniser)
  logic [7:0]  mS1, mS2, mPrev, mLatch, mSense, mFall, mAck;
  logic [15:0] mMask, mOut, mPend;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= '1; mS2 <= '1; mPrev <= '1; mLatch <= '0;
      mSense <= '0; mMask <= '0; mOut <= '0;
    end else begin
      mFall = mPrev & ~mS2;
      for (int n = 0; n < 8; n++) begin
        mAck[n]  = regWrEn && (regAddr == 2'd2) && regWrData[31-n];
        mPend[n] = mSense[n] ? mLatch[n] : ~mS2[n];
        mPend[8+n] = ~intReqN[n];
      end
      mOut <= mPend & mMask;
      for (int n = 0; n < 8; n++)
        mLatch[n] <= mSense[n] ? ((mLatch[n] & ~mAck[n]) | mFall[n]) : 1'b0;
      mS1 <= extPinN; mS2 <= mS1; mPrev <= mS2;
      if (regWrEn && regAddr == 2'd0)
        for (int n = 0; n < 8; n++) mSense[n] <= regWrData[15-n];
      if (regWrEn && regAddr == 2'd1)
        for (int b = 0; b < 16; b++) mMask[b] <= regWrData[31-b];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1: reset state
    check("R1 irqPend after reset", 32'(irqPend), 32'h0);
    rdReg(2'd0, rd); check("R1 sense reset", rd, 32'h0);
    rdReg(2'd1, rd); check("R1 mask reset", rd, 32'h0);
    // R10: field widths on readback
    wrReg(2'd1, 32'hFFFF_FFFF);
    rdReg(2'd1, rd); check("R10 mask readback", rd, 32'hFFFF_0000);
    wrReg(2'd0, 32'hFFFF_FFFF);
    rdReg(2'd0, rd); check("R10 sense readback", rd, 32'h0000_FF00);
    wrReg(2'd3, 32'h0000_0000);
    rdReg(2'd0, rd); check("R10 reserved write ignored", rd, 32'h0000_FF00);
    rdReg(2'd2, rd); check("R10 ack reads zero", rd, 32'h0);
    rdReg(2'd3, rd); check("R10 reserved reads zero", rd, 32'h0);
    // edge mode on pins 2 and 5 (bits 13 and 10)
    wrReg(2'd0, 32'h0000_2400);
    tick(2);
    // R2: level pin 0 latency
    extPinN[0] = 1'b0;
    tick(2); check("R2 level not yet", 32'(irqPend[0]), 32'h0);
    tick(1); check("R2 level asserted", 32'(irqPend[0]), 32'h1);
    // R6: acknowledge ignored in level mode
    wrReg(2'd2, 32'h8000_0000);
    tick(2); check("R6 level survives ack", 32'(irqPend[0]), 32'h1);
    extPinN[0] = 1'b1;
    tick(3); check("R2 level released", 32'(irqPend[0]), 32'h0);
    // R3: falling edge capture on pin 2
    extPinN[2] = 1'b0;
    tick(3); check("R3 edge not yet", 32'(irqPend[2]), 32'h0);
    tick(1); check("R3 edge captured", 32'(irqPend[2]), 32'h1);
    extPinN[2] = 1'b1;
    tick(4); check("R3 capture held after release", 32'(irqPend[2]), 32'h1);
    // R5: ack pin 2 only, pin 5 keeps its capture
    extPinN[5] = 1'b0;
    tick(4);
    wrReg(2'd2, 32'h2000_0000);
    tick(1);
    check("R5 ack clears pin 2", 32'(irqPend[2]), 32'h0);
    check("R5 zero bits keep pin 5", 32'(irqPend[5]), 32'h1);
    // R4: rising edge and steady level set nothing
    wrReg(2'd2, 32'h0400_0000);
    tick(2); check("R5 ack clears pin 5", 32'(irqPend[5]), 32'h0);
    tick(3); check("R4 steady low sets nothing", 32'(irqPend[5]), 32'h0);
    extPinN[5] = 1'b1;
    tick(5); check("R4 rising edge ignored", 32'(irqPend[5]), 32'h0);
    // R7: ack on the cycle a new falling edge is detected
    extPinN[5] = 1'b0;
    tick(4); check("R7 first capture", 32'(irqPend[5]), 32'h1);
    extPinN[5] = 1'b1;
    tick(4);
    extPinN[5] = 1'b0;
    tick(2);
    wrReg(2'd2, 32'h0400_0000);
    tick(2); check("R7 capture kept on ack collision", 32'(irqPend[5]), 32'h1);
    wrReg(2'd2, 32'h0400_0000);
    tick(1); check("R5 later ack clears", 32'(irqPend[5]), 32'h0);
    // R8: mask hides and restores a capture
    extPinN[2] = 1'b0;
    tick(4); check("R8 enabled capture", 32'(irqPend[2]), 32'h1);
    wrReg(2'd1, 32'hDFFF_0000);
    tick(1); check("R8 masked", 32'(irqPend[2]), 32'h0);
    wrReg(2'd1, 32'hFFFF_0000);
    tick(1); check("R8 unmasked capture returns", 32'(irqPend[2]), 32'h1);
    // R9: on-chip source 11 is level only
    intReqN[3] = 1'b0;
    tick(1); check("R9 internal asserted", 32'(irqPend[11]), 32'h1);
    wrReg(2'd0, 32'hFFFF_FFFF);
    intReqN[3] = 1'b1;
    tick(1); check("R9 internal not latched", 32'(irqPend[11]), 32'h0);
    wrReg(2'd0, 32'h0000_2400);
    tick(1);
    check("R11 model agrees after directed", 32'(irqPend), 32'(mOut));
    // Random phase against the cycle model
    for (int c = 0; c < 3000; c++) begin
      check("R11 random irqPend", 32'(irqPend), 32'(mOut));
      regWrEn = 1'b0;
      if (($urandom % 6) == 0) extPinN[$urandom % 8] ^= 1'b1;
      if (($urandom % 10) == 0) intReqN[$urandom % 8] ^= 1'b1;
      if (($urandom % 7) == 0) begin
        regAddr   = 2'($urandom % 4);
        regWrData = $urandom;
        regWrEn   = 1'b1;
      end
      @(negedge clk);
    end
    regWrEn = 1'b0;
    tick(1);
    check("R11 final agreement", 32'(irqPend), 32'(mOut));
    done = 1'b1;
    summary();
  end

endmodule